// File: doc/BRIEF.md
# Reloadable Programmable Clock Divider

This block makes one divided clock from its parent clock. The output period is a whole number of parent cycles, set by an active ratio. Software reaches the block through a small synchronous register bus with two words. The control word is at address 0 and the ratio word is at address 1. A new ratio is first written into a staging field. It is picked up only after a reload handshake. Changes of ratio and changes of the gate take effect only at a period boundary, so the output never shows a runt pulse.

Software uses it in this order:
1. Write the wanted ratio into bits [13:8] of the ratio word.
2. Set the reload-force flag (control bit 1).
3. Set the reload trigger (control bit 8).
4. After the switch, clear control bits [7:0] and the trigger.

Control bit 25 gates the output. Only ratios 4, 5, 6 and 8 are accepted. Any other staged value is dropped at reload.

Top module: `reload_clk_divider`

## Requirements
- R1: Reset leaves the registers and the output as follows:
  - the control word reads 0x02000000 (enable bit 25 set);
  - the ratio word reads 0x00000400 (staged field = 4);
  - the output runs at ratio 4, with 2 cycles high and 2 cycles low.
- R2: Address 0 reads back the last value written to the control word, and address 1 reads back the last value written to the ratio word. Read data is valid in the same cycle as the address.
- R3: Writing the staged field (ratio word bits [13:8]) without a reload does not change the output period.
- R4: A staged ratio is applied only when the state "control bit 8 set AND control bit 1 set" begins. If bit 8 is set while bit 1 is clear, nothing changes.
- R5: Once a ratio has been applied, holding the trigger set, or writing again with the trigger still set, applies nothing new. A new ratio needs the trigger to be cleared and then set again.
- R6: A staged value that is not 4, 5, 6 or 8 (0 included) is ignored at reload, and the previous ratio stays active.
- R7: For an active ratio N, the output period is N parent cycles. Each period starts high, stays high for floor(N/2) cycles, then stays low for the rest.
- R8: A new ratio starts only at the start of a period, after a complete low phase. High and low pulses are never shorter than 2 parent cycles.
- R9: Clearing control bit 25 stops the output low at the end of the current period. Setting it again restarts the output at a period start with a full high phase. Bit 25 reads back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Word address: 0 selects the control word, 1 selects the ratio word |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at bus_addr, valid in the same cycle |
| clk_out | output | 1 | Divided and gated output clock, driven from a register |

## Verification
- **Reads:** read data depends only on the address, so reads are sampled 1 ns after a falling edge at which the address was set.
- **Writes:** a write takes effect at the next rising edge. A reload request forms one edge later. The new ratio is adopted at the next period boundary, which is at most 8 parent cycles away.
- **Settling:** for this reason the checks wait 24 cycles after each handshake before they measure anything.
- **Measurement:** each measurement waits for a low sample, then for a rising transition. It then counts whole high and low phases on falling-edge samples, so it never counts a period that is only partly over. A monitor that runs for the whole test records any pulse shorter than 2 cycles.

// File: rtl/cdr_pkg.sv
// Package: shared constants and the ratio legality rule for the divider.
// Assumes: the two register words are indexed 0 (control) and 1 (ratio).
package cdr_pkg;
    localparam int NUM_REGS  = 2;
    localparam int CTRL_IDX  = 0;
    localparam int RATIO_IDX = 1;

    // Only a small set of integer ratios is supported by the output stage.
    function automatic logic ratio_is_legal(input logic [31:0] r);
        return (r == 32'd4) || (r == 32'd5) || (r == 32'd6) || (r == 32'd8);
    endfunction
endpackage

// File: rtl/cdr_regs.sv
// Module: register file holding the control word and the ratio word.
// Assumes: single-cycle synchronous writes; reads are combinational on the
// address; unmapped addresses read zero and ignore writes.
module cdr_regs #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] CTRL_RST  = '0,
    parameter logic [DATA_W-1:0] RATIO_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] ratio_q
);
    localparam int NREG = cdr_pkg::NUM_REGS;
    localparam logic [DATA_W-1:0] RST_TAB [NREG] = '{CTRL_RST, RATIO_RST};

    logic [DATA_W-1:0] regs_q [NREG];

    // Store a written word into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= RST_TAB[i];
        end else if (bus_we) begin
            for (int i = 0; i < NREG; i++)
                if (bus_addr == ADDR_W'(i)) regs_q[i] <= bus_wdata;
        end
    end

    // Return the addressed word, or zero for an unmapped address.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NREG; i++)
            if (bus_addr == ADDR_W'(i)) bus_rdata = regs_q[i];
    end

    assign ctrl_q  = regs_q[cdr_pkg::CTRL_IDX];
    assign ratio_q = regs_q[cdr_pkg::RATIO_IDX];
endmodule

// File: rtl/cdr_reload.sv
// Module: reload handshake. It detects the start of "force AND trigger" and
// latches a legal staged ratio as pending until the divider consumes it.
// Assumes: the control word is in the same clock domain; take marks the last
// cycle of an output period.
module cdr_reload #(
    parameter int DATA_W    = 32,
    parameter int RATIO_W   = 6,
    parameter int RATIO_LSB = 8,
    parameter int FORCE_BIT = 1,
    parameter int TRIG_BIT  = 8,
    parameter int RATIO_RST = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  ctrl_q,
    input  logic [DATA_W-1:0]  ratio_q,
    input  logic               take,
    output logic               pend_valid,
    output logic [RATIO_W-1:0] pend_ratio
);
    logic               armed;
    logic               armed_d;
    logic               req;
    logic [RATIO_W-1:0] staged;
    logic               staged_ok;

    assign armed     = ctrl_q[FORCE_BIT] & ctrl_q[TRIG_BIT];
    assign req       = armed & ~armed_d;
    assign staged    = ratio_q[RATIO_LSB +: RATIO_W];
    assign staged_ok = cdr_pkg::ratio_is_legal(32'(staged));

    // Remember the armed state so that only its start raises a request.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_d <= 1'b0;
        else        armed_d <= armed;
    end

    // Hold a legal request as pending; clear it when the divider takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_ratio <= RATIO_W'(RATIO_RST);
        end else if (req && staged_ok) begin
            pend_valid <= 1'b1;
            pend_ratio <= staged;
        end else if (take) begin
            pend_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/cdr_core.sv
// Module: integer divider with a registered output. It adopts a pending
// ratio and the gate request only at a period boundary.
// Assumes: the active ratio is always >= 2; the counter keeps running while
// the output is gated.
module cdr_core #(
    parameter int RATIO_W   = 6,
    parameter int RATIO_RST = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gate_en,
    input  logic               pend_valid,
    input  logic [RATIO_W-1:0] pend_ratio,
    output logic               take,
    output logic [RATIO_W-1:0] act_ratio,
    output logic [RATIO_W-1:0] cnt,
    output logic               run,
    output logic               clk_out
);
    logic [RATIO_W-1:0] cnt_n;
    logic [RATIO_W-1:0] ratio_n;
    logic               run_n;
    logic               last;

    // Work out the next counter, ratio and gate values at the period boundary.
    always_comb begin
        last    = (cnt == act_ratio - RATIO_W'(1));
        cnt_n   = last ? '0 : cnt + RATIO_W'(1);
        ratio_n = (last && pend_valid) ? pend_ratio : act_ratio;
        run_n   = last ? gate_en : run;
    end

    assign take = last;

    // Advance the period state and register the output level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= RATIO_W'(RATIO_RST - 1);
            act_ratio <= RATIO_W'(RATIO_RST);
            run       <= 1'b1;
            clk_out   <= 1'b0;
        end else begin
            cnt       <= cnt_n;
            act_ratio <= ratio_n;
            run       <= run_n;
            clk_out   <= run_n && (cnt_n < (ratio_n >> 1));
        end
    end
endmodule

// File: rtl/reload_clk_divider.sv
// Module: top of the reloadable divider. Connects the register file, the
// reload handshake and the divider core.
// Assumes: the bus and the divider share the parent clock; reset is
// synchronous and active low.
module reload_clk_divider #(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 32,
    parameter int RATIO_W   = 6,
    parameter int RATIO_LSB = 8,
    parameter int FORCE_BIT = 1,
    parameter int TRIG_BIT  = 8,
    parameter int EN_SHIFT  = 24,
    parameter int RATIO_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              clk_out
);
    localparam int EN_BIT = FORCE_BIT + EN_SHIFT;
    localparam logic [DATA_W-1:0] CTRL_RST_W  = DATA_W'(1) << EN_BIT;
    localparam logic [DATA_W-1:0] RATIO_RST_W = DATA_W'(RATIO_RST) << RATIO_LSB;

    logic [DATA_W-1:0]  ctrl_q;
    logic [DATA_W-1:0]  ratio_q;
    logic               pend_valid;
    logic [RATIO_W-1:0] pend_ratio;
    logic               take;
    logic [RATIO_W-1:0] act_ratio;
    logic [RATIO_W-1:0] cnt;
    logic               run;

    cdr_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CTRL_RST(CTRL_RST_W), .RATIO_RST(RATIO_RST_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctrl_q(ctrl_q), .ratio_q(ratio_q)
    );

    cdr_reload #(
        .DATA_W(DATA_W), .RATIO_W(RATIO_W), .RATIO_LSB(RATIO_LSB),
        .FORCE_BIT(FORCE_BIT), .TRIG_BIT(TRIG_BIT), .RATIO_RST(RATIO_RST)
    ) u_reload (
        .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .ratio_q(ratio_q),
        .take(take), .pend_valid(pend_valid), .pend_ratio(pend_ratio)
    );

    cdr_core #(
        .RATIO_W(RATIO_W), .RATIO_RST(RATIO_RST)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .gate_en(ctrl_q[EN_BIT]),
        .pend_valid(pend_valid), .pend_ratio(pend_ratio), .take(take),
        .act_ratio(act_ratio), .cnt(cnt), .run(run), .clk_out(clk_out)
    );
endmodule

// File: rtl/cdr_chk.sv
// Module: assertion checker, bound to the divider top.
// Assumes: it is attached through the bind below to internal top-level nets.
module cdr_chk #(
    parameter int ADDR_W  = 2,
    parameter int DATA_W  = 32,
    parameter int RATIO_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  ctrl_q,
    input logic               pend_valid,
    input logic [RATIO_W-1:0] act_ratio,
    input logic [RATIO_W-1:0] cnt,
    input logic               run,
    input logic               clk_out
);
    p_ctrl_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(0)) |=> ctrl_q == $past(bus_wdata));

    p_change_needs_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_ratio != $past(act_ratio)) |-> $past(pend_valid));

    p_active_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cdr_pkg::ratio_is_legal(32'(act_ratio)));

    p_rise_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out) |-> (cnt == '0));

    p_switch_after_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_ratio != $past(act_ratio)) |-> (cnt == '0 && !$past(clk_out)));

    p_gated_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !clk_out);
endmodule

bind reload_clk_divider cdr_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATIO_W(RATIO_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .pend_valid(pend_valid),
    .act_ratio(act_ratio), .cnt(cnt), .run(run), .clk_out(clk_out)
);

// File: tb/tb_reload_clk_divider.sv
`timescale 1ns/1ps
module tb_reload_clk_divider;
    localparam logic [31:0] EN  = 32'h0200_0000;
    localparam logic [31:0] FRC = 32'h0000_0002;
    localparam logic [31:0] TRG = 32'h0000_0100;

    // {staged[7:0], force[3:0], expected active ratio[3:0]}
    localparam int NV = 11;
    localparam logic [15:0] VEC [NV] = '{
        16'h05_1_5, 16'h06_1_6, 16'h08_1_8,
        16'h07_1_8,  // R6 illegal 7 ignored
        16'h00_1_8,  // R6 zero ignored
        16'h04_0_8,  // R4 trigger without force
        16'h04_1_4, 16'h05_1_5,
        16'h03_1_5,  // R6 illegal 3
        16'h3F_1_5,  // R6 illegal 63
        16'h06_1_6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        clk_out;

    int total = 0;
    int bad = 0;
    int short_pulses = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    reload_clk_divider dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_out(clk_out)
    );

    // R8 monitor: every completed pulse must last at least 2 cycles
    int  run_len = 0;
    bit  seen_edge = 1'b0;
    logic prev_s = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (clk_out === prev_s) run_len++;
            else begin
                if (seen_edge && run_len < 2) short_pulses++;
                seen_edge = 1'b1;
                run_len = 1;
            end
            prev_s = clk_out;
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic measure(output int hi, output int lo);
        int guard;
        hi = 0; lo = 0; guard = 0;
        @(negedge clk);
        while (clk_out !== 1'b0 && guard < 100) begin @(negedge clk); guard++; end
        while (clk_out !== 1'b1 && guard < 100) begin @(negedge clk); guard++; end
        while (clk_out === 1'b1 && guard < 100) begin hi++; @(negedge clk); guard++; end
        while (clk_out === 1'b0 && guard < 100) begin lo++; @(negedge clk); guard++; end
    endtask

    task automatic settle();
        repeat (24) @(negedge clk);
    endtask

    task automatic check_ratio(input string tag, input int n);
        int hi, lo;
        measure(hi, lo);
        check({tag, " high"}, hi, n / 2);
        check({tag, " low"}, lo, n - n / 2);
    endtask

    initial begin
        logic [31:0] rd;
        int highs;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(2'd0, rd); check("R1 ctrl reset", rd, 32'h0200_0000);
        bus_read(2'd1, rd); check("R1 ratio reset", rd, 32'h0000_0400);
        check_ratio("R1 reset ratio 4", 4);

        // R2 readback of both words
        bus_write(2'd1, 32'hA5A5_1234);
        bus_read(2'd1, rd); check("R2 ratio readback", rd, 32'hA5A5_1234);
        bus_write(2'd0, 32'h02F0_0000);
        bus_read(2'd0, rd); check("R2 ctrl readback", rd, 32'h02F0_0000);
        bus_write(2'd0, EN);

        // R3 staging alone does not change the output
        bus_write(2'd1, 32'h0000_0800);
        settle();
        check_ratio("R3 staged only", 4);

        // R4 R6 R7 vector walk: stage, force, trigger, then clear
        for (int i = 0; i < NV; i++) begin
            bus_write(2'd1, {16'h0, VEC[i][15:8], 8'h00});
            bus_write(2'd0, EN | (VEC[i][4] ? FRC : 32'h0));
            bus_write(2'd0, EN | (VEC[i][4] ? FRC : 32'h0) | TRG);
            bus_write(2'd0, EN);
            settle();
            check_ratio($sformatf("R7 vec%0d ratio", i), int'(VEC[i][3:0]));
        end

        // R5 holding the trigger set applies nothing new
        bus_write(2'd1, 32'h0000_0800);
        bus_write(2'd0, EN | FRC | TRG);
        settle();
        check_ratio("R5 first apply 8", 8);
        bus_write(2'd1, 32'h0000_0500);
        bus_write(2'd0, EN | FRC | TRG);
        settle();
        check_ratio("R5 held trigger keeps 8", 8);
        bus_write(2'd0, EN);
        bus_write(2'd0, EN | FRC | TRG);
        bus_write(2'd0, EN);
        settle();
        check_ratio("R5 retrigger applies 5", 5);

        // R9 gating stops low and restarts with a full high phase
        bus_write(2'd0, 32'h0);
        bus_read(2'd0, rd); check("R9 enable readback", rd[25], 0);
        repeat (12) @(negedge clk);
        highs = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (clk_out === 1'b1) highs++;
        end
        check("R9 gated output high samples", highs, 0);
        bus_write(2'd0, EN);
        check_ratio("R9 restart ratio 5", 5);

        // R8 minimum pulse width across the whole run
        check("R8 short pulses", short_pulses, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule